// File: doc/BRIEF.md
# Vector Loop State Register

This block holds the 64-bit loop-control state of a scalable-vector core. The state is the maximum element count (MVL), the active vector length (VL), the source and destination element steps, the two sub-element steps, five 2-bit remap selectors, a 5-bit remap enable mask, the pack and unpack ordering flags, a 7-bit parallelism hint, a remap persistence flag and a vertical-first flag. The register drives the whole state onto `state_o` at all times.

Two operations write the register. A length-set operation takes a requested length from one of three sources: an immediate, a general register value or a count register. It can also load a new MVL from an immediate. It stores VL as the smaller of the request and the MVL, and it returns that VL on a result port. A raw write loads all 64 bits at once. Both operations check the incoming values. An illegal value leaves the register as it was and raises a one-cycle trap pulse. Every effect appears on the outputs in the cycle after the operation is presented.

Field positions, with bit 0 as the least significant bit:

| Field | Bits |
|---|---|
| MVL | [6:0] |
| VL | [13:7] |
| source step | [20:14] |
| destination step | [27:21] |
| destination sub-step | [29:28] |
| source sub-step | [31:30] |
| remap selectors | [41:32] |
| remap enables | [46:42] |
| reserved | [52:47] |
| pack | 53 |
| unpack | 54 |
| hint | [61:55] |
| persistence | 62 |
| vertical-first | 63 |

Top module: `vsr_state_reg`

## Requirements
- R1: After reset, `state_o` is all zero and `trap_o` and `res_vld_o` are low.
- R2: A length-set operation stores VL = min(request, MVL). `len_src` selects the request as follows: 2'b01 selects `len_gpr`, 2'b10 selects `len_cnt`, and 2'b00 or 2'b11 select `len_imm`. This holds even for requests far above 127.
- R3: When `len_set_mvl` is high, a length-set operation loads MVL from `len_mvl_imm`, and that new MVL is the cap for VL. When `len_set_mvl` is low, MVL keeps its value.
- R4: One cycle after a legal length-set operation, `res_vld_o` is high and `res_o` holds the new VL. `res_vld_o` stays low when `len_rt_zero` is high.
- R5: A legal raw write loads every field from `raw_wdata`. If the written VL exceeds the written MVL, VL is stored as MVL.
- R6: Reserved bits [52:47] always read as zero, whatever a raw write supplies.
- R7: A raw write is illegal when MVL > 64, VL > 64, source step >= 64 or destination step >= 64. An illegal raw write pulses `trap_o` in the next cycle and leaves the register unchanged.
- R8: A length-set operation whose new MVL exceeds 64 pulses `trap_o` and changes nothing. `res_vld_o` stays low.
- R9: The persistence bit [62] is cleared by a length-set operation that changes VL or MVL. A length-set operation that changes neither keeps the bit.
- R10: A length-set operation that changes VL zeroes both element steps and both sub-steps. One that leaves VL the same keeps them.
- R11: When `raw_we` and `len_req` are high in the same cycle, the raw write takes effect and the length-set operation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_we | input | 1 | Raw 64-bit write strobe |
| raw_wdata | input | 64 | Raw write value |
| len_req | input | 1 | Length-set operation strobe |
| len_src | input | 2 | Request source select |
| len_imm | input | 7 | Immediate requested length |
| len_gpr | input | REQ_W | Register-sourced requested length |
| len_cnt | input | REQ_W | Count-register requested length |
| len_set_mvl | input | 1 | Also load MVL from `len_mvl_imm` |
| len_mvl_imm | input | 7 | Immediate MVL |
| len_rt_zero | input | 1 | Destination is register zero; suppress the result |
| state_o | output | 64 | Current register contents |
| trap_o | output | 1 | Illegal-value pulse |
| res_vld_o | output | 1 | Result valid pulse |
| res_o | output | 7 | VL produced by the last length-set operation |

## Verification
Length-set operations are issued from each of the three request sources. The requests fall below the cap, equal to it and far above it; this separates a wrong source choice from a wrong clamp. Some operations repeat the current VL and others change it. This distinguishes a side effect that fires on every operation from one that fires only on a real change of VL or MVL. Raw writes probe each limit at its last legal value and at its first illegal value, and they set the reserved bits. A random mix of both operations, including cycles that issue both at once, is compared on every clock against a behavioural model.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int LEN_W  = 7;
  localparam int SUB_W  = 2;
  localparam int SEL_W  = 2;
  localparam int ENB_W  = 5;
  localparam int RSV_W  = 6;
  localparam int HINT_W = 7;

  // Field order is MSB first; positions matter to software decoding the word.
  typedef struct packed {
    logic              vfirst;
    logic              rmpst;
    logic [HINT_W-1:0] hint;
    logic              unpack;
    logic              pack;
    logic [RSV_W-1:0]  rsvd;
    logic [ENB_W-1:0]  remap_en;
    logic [SEL_W-1:0]  sel_o1;
    logic [SEL_W-1:0]  sel_o0;
    logic [SEL_W-1:0]  sel_i2;
    logic [SEL_W-1:0]  sel_i1;
    logic [SEL_W-1:0]  sel_i0;
    logic [SUB_W-1:0]  ssub;
    logic [SUB_W-1:0]  dsub;
    logic [LEN_W-1:0]  dstep;
    logic [LEN_W-1:0]  sstep;
    logic [LEN_W-1:0]  vl;
    logic [LEN_W-1:0]  mvl;
  } vstate_t;

  typedef enum logic [1:0] {
    SRC_IMM  = 2'b00,
    SRC_GPR  = 2'b01,
    SRC_CNT  = 2'b10,
    SRC_IMMX = 2'b11
  } len_src_e;

  function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                                input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/vsr_len_clamp.sv
module vsr_len_clamp
  import vsr_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input  logic [1:0]       src,
  input  logic [LEN_W-1:0] imm,
  input  logic [REQ_W-1:0] gpr,
  input  logic [REQ_W-1:0] cnt,
  input  logic [LEN_W-1:0] cap,
  output logic [LEN_W-1:0] vl
);
  localparam int PAD_W = REQ_W - LEN_W;

  logic [REQ_W-1:0] req_w;
  logic [REQ_W-1:0] cap_w;

  always_comb begin
    unique case (len_src_e'(src))
      SRC_GPR: req_w = gpr;
      SRC_CNT: req_w = cnt;
      default: req_w = {{PAD_W{1'b0}}, imm};
    endcase
  end

  assign cap_w = {{PAD_W{1'b0}}, cap};
  assign vl    = (req_w > cap_w) ? cap : req_w[LEN_W-1:0];
endmodule

// File: rtl/vsr_range_chk.sv
module vsr_range_chk
  import vsr_pkg::*;
#(
  parameter int LEN_LIMIT = 64
) (
  input  logic [LEN_W-1:0] mvl,
  input  logic [LEN_W-1:0] vl,
  input  logic [LEN_W-1:0] sstep,
  input  logic [LEN_W-1:0] dstep,
  output logic             illegal
);
  localparam logic [LEN_W-1:0] LIM = LEN_W'(LEN_LIMIT);

  assign illegal = (mvl > LIM) || (vl > LIM) || (sstep >= LIM) || (dstep >= LIM);
endmodule

// File: rtl/vsr_state_reg.sv
module vsr_state_reg
  import vsr_pkg::*;
#(
  parameter int REQ_W     = 16,
  parameter int LEN_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_we,
  input  logic [63:0]       raw_wdata,
  input  logic              len_req,
  input  logic [1:0]        len_src,
  input  logic [6:0]        len_imm,
  input  logic [REQ_W-1:0]  len_gpr,
  input  logic [REQ_W-1:0]  len_cnt,
  input  logic              len_set_mvl,
  input  logic [6:0]        len_mvl_imm,
  input  logic              len_rt_zero,
  output logic [63:0]       state_o,
  output logic              trap_o,
  output logic              res_vld_o,
  output logic [6:0]        res_o
);
  localparam logic [LEN_W-1:0] LIM = LEN_W'(LEN_LIMIT);

  vstate_t          cur_q, nxt_c, raw_c, raw_in;
  logic             upd_en;
  logic             trap_d, trap_q;
  logic             rv_d, rv_q;
  logic [LEN_W-1:0] res_q;
  logic [LEN_W-1:0] new_mvl, cl_vl;
  logic             raw_bad, len_bad;

  assign raw_in = vstate_t'(raw_wdata);

  vsr_range_chk #(.LEN_LIMIT(LEN_LIMIT)) u_chk (
    .mvl     (raw_in.mvl),
    .vl      (raw_in.vl),
    .sstep   (raw_in.sstep),
    .dstep   (raw_in.dstep),
    .illegal (raw_bad)
  );

  assign new_mvl = len_set_mvl ? len_mvl_imm : cur_q.mvl;
  assign len_bad = new_mvl > LIM;

  vsr_len_clamp #(.REQ_W(REQ_W)) u_clamp (
    .src (len_src),
    .imm (len_imm),
    .gpr (len_gpr),
    .cnt (len_cnt),
    .cap (new_mvl),
    .vl  (cl_vl)
  );

  always_comb begin
    raw_c      = raw_in;
    raw_c.rsvd = '0;
    raw_c.vl   = min_len(raw_in.vl, raw_in.mvl);
  end

  // next-state
  always_comb begin
    nxt_c  = cur_q;
    upd_en = 1'b0;
    trap_d = 1'b0;
    rv_d   = 1'b0;
    if (raw_we) begin
      if (raw_bad) begin
        trap_d = 1'b1;
      end else begin
        upd_en = 1'b1;
        nxt_c  = raw_c;
      end
    end else if (len_req) begin
      if (len_bad) begin
        trap_d = 1'b1;
      end else begin
        upd_en    = 1'b1;
        nxt_c.mvl = new_mvl;
        nxt_c.vl  = cl_vl;
        if (cl_vl != cur_q.vl) begin
          nxt_c.sstep = '0;
          nxt_c.dstep = '0;
          nxt_c.ssub  = '0;
          nxt_c.dsub  = '0;
        end
        if ((cl_vl != cur_q.vl) || (new_mvl != cur_q.mvl)) nxt_c.rmpst = 1'b0;
        rv_d = ~len_rt_zero;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (upd_en) begin
      cur_q <= nxt_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      trap_q <= trap_d;
      rv_q   <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (rv_d) begin
      res_q <= cl_vl;
    end
  end

  assign state_o   = cur_q;
  assign trap_o    = trap_q;
  assign res_vld_o = rv_q;
  assign res_o     = res_q;

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.rsvd == '0);

  // R2
  vl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.vl <= cur_q.mvl);

  // R7
  mvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.mvl <= LIM);

  // R7
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_d |=> (cur_q == $past(cur_q)) && trap_o);

  // R4
  res_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> (res_o == cur_q.vl));

  // R8
  trap_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !res_vld_o);
endmodule

// File: tb/test_vsr_state_reg.sv
`timescale 1ns/1ps
module test_vsr_state_reg;
  localparam int REQ_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             raw_we;
  logic [63:0]      raw_wdata;
  logic             len_req;
  logic [1:0]       len_src;
  logic [6:0]       len_imm;
  logic [REQ_W-1:0] len_gpr;
  logic [REQ_W-1:0] len_cnt;
  logic             len_set_mvl;
  logic [6:0]       len_mvl_imm;
  logic             len_rt_zero;
  logic [63:0]      state_o;
  logic             trap_o;
  logic             res_vld_o;
  logic [6:0]       res_o;

  int n_chk = 0;
  int n_err = 0;

  logic [63:0] m_state;
  logic        e_trap, e_rv;
  logic [6:0]  e_res;

  vsr_state_reg #(.REQ_W(REQ_W), .LEN_LIMIT(64)) i_vsr_state_reg (
    .clk(clk), .rst_n(rst_n), .raw_we(raw_we), .raw_wdata(raw_wdata),
    .len_req(len_req), .len_src(len_src), .len_imm(len_imm),
    .len_gpr(len_gpr), .len_cnt(len_cnt), .len_set_mvl(len_set_mvl),
    .len_mvl_imm(len_mvl_imm), .len_rt_zero(len_rt_zero),
    .state_o(state_o), .trap_o(trap_o), .res_vld_o(res_vld_o), .res_o(res_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference of one cycle
  task automatic model_step();
    int mv, vl, ss, ds, req, nm, nvl;
    e_trap = 1'b0;
    e_rv   = 1'b0;
    if (raw_we) begin
      mv = raw_wdata[6:0]; vl = raw_wdata[13:7];
      ss = raw_wdata[20:14]; ds = raw_wdata[27:21];
      if (mv > 64 || vl > 64 || ss >= 64 || ds >= 64) e_trap = 1'b1;
      else begin
        m_state = raw_wdata;
        m_state[52:47] = '0;
        if (vl > mv) m_state[13:7] = 7'(mv);
      end
    end else if (len_req) begin
      nm = len_set_mvl ? int'(len_mvl_imm) : int'(m_state[6:0]);
      if (nm > 64) e_trap = 1'b1;
      else begin
        case (len_src)
          2'b01:   req = int'(len_gpr);
          2'b10:   req = int'(len_cnt);
          default: req = int'(len_imm);
        endcase
        nvl = (req < nm) ? req : nm;
        if (nvl != int'(m_state[13:7])) m_state[31:14] = '0;
        if (nvl != int'(m_state[13:7]) || nm != int'(m_state[6:0])) m_state[62] = 1'b0;
        m_state[6:0]  = 7'(nm);
        m_state[13:7] = 7'(nvl);
        e_rv = !len_rt_zero;
        if (e_rv) e_res = 7'(nvl);
      end
    end
  endtask

  task automatic clr_in();
    raw_we = 0; raw_wdata = '0; len_req = 0; len_src = 0; len_imm = 0;
    len_gpr = 0; len_cnt = 0; len_set_mvl = 0; len_mvl_imm = 0; len_rt_zero = 0;
  endtask

  task automatic cycle(input string tag);
    model_step();
    @(posedge clk);
    #2;
    check({tag, " state"}, state_o, m_state);
    check({tag, " trap"}, {63'd0, trap_o}, {63'd0, e_trap});
    check({tag, " rvld"}, {63'd0, res_vld_o}, {63'd0, e_rv});
    if (e_rv) check({tag, " res"}, {57'd0, res_o}, {57'd0, e_res});
    clr_in();
  endtask

  function automatic logic [63:0] mk(input int mv, input int vl, input int ss,
                                     input int ds, input logic [35:0] upper);
    logic [63:0] w;
    w = {upper, 28'd0};
    w[6:0] = 7'(mv); w[13:7] = 7'(vl); w[20:14] = 7'(ss); w[27:21] = 7'(ds);
    return w;
  endfunction

  task automatic do_raw(input logic [63:0] d, input string tag);
    raw_we = 1; raw_wdata = d; cycle(tag);
  endtask

  task automatic do_len(input logic [1:0] s, input int imm, input int gpr, input int cnt,
                        input logic setm, input int mimm, input logic rz, input string tag);
    len_req = 1; len_src = s; len_imm = 7'(imm); len_gpr = REQ_W'(gpr);
    len_cnt = REQ_W'(cnt); len_set_mvl = setm; len_mvl_imm = 7'(mimm); len_rt_zero = rz;
    cycle(tag);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    clr_in();
    m_state = '0; e_res = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    check("R1 state", state_o, 64'd0);
    check("R1 trap", {63'd0, trap_o}, 64'd0);
    check("R1 rvld", {63'd0, res_vld_o}, 64'd0);

    // R5 legal raw write, R6 reserved bits set in data
    do_raw(mk(20, 12, 3, 4, 36'hF_FFFF_FFFF), "R5 raw legal");
    do_raw(mk(10, 40, 1, 2, 36'h4_0000_0000), "R5 raw trunc");
    do_raw(mk(30, 5, 0, 0, 36'h0_01F8_0000), "R6 rsvd");
    // R7 boundaries
    do_raw(mk(64, 64, 63, 63, 36'h4_0000_0000), "R7 edge legal");
    do_raw(mk(65, 3, 0, 0, 36'h0), "R7 mvl 65");
    do_raw(mk(64, 65, 0, 0, 36'h0), "R7 vl 65");
    do_raw(mk(64, 3, 64, 0, 36'h0), "R7 src 64");
    do_raw(mk(64, 3, 0, 64, 36'h0), "R7 dst 64");
    // R2 sources and clamp; R9/R10 change effects
    do_len(2'b00, 100, 0, 0, 1'b0, 0, 1'b0, "R2 imm clamp");
    do_raw(mk(40, 9, 7, 8, 36'h4_0000_0000), "R9 setup");
    do_len(2'b01, 0, 9, 0, 1'b0, 0, 1'b0, "R9 R10 same vl");
    do_len(2'b10, 0, 0, 5, 1'b0, 0, 1'b0, "R10 cnt change");
    do_len(2'b01, 0, 16'hFFFF, 0, 1'b0, 0, 1'b0, "R2 gpr big");
    do_len(2'b11, 3, 0, 0, 1'b0, 0, 1'b0, "R2 imm alias");
    do_raw(mk(40, 3, 7, 8, 36'h4_0000_0000), "R9 setup2");
    do_len(2'b00, 3, 0, 0, 1'b1, 50, 1'b0, "R9 mvl change");
    // R3
    do_len(2'b00, 60, 0, 0, 1'b1, 12, 1'b0, "R3 new mvl");
    do_len(2'b00, 60, 0, 0, 1'b1, 0, 1'b0, "R3 mvl zero");
    // R4
    do_len(2'b00, 7, 0, 0, 1'b1, 64, 1'b1, "R4 rt zero");
    // R8
    do_len(2'b00, 2, 0, 0, 1'b1, 70, 1'b0, "R8 mvl 70");
    // R11
    raw_we = 1; raw_wdata = mk(33, 22, 1, 1, 36'h0);
    do_len(2'b00, 5, 0, 0, 1'b1, 8, 1'b0, "R11 both");

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      raw_we  = ($urandom % 3) == 0;
      raw_wdata = mk($urandom % 70, $urandom % 70, $urandom % 68, $urandom % 68,
                     {$urandom, 4'($urandom)});
      len_req = ($urandom % 2) == 0;
      len_src = 2'($urandom);
      len_imm = 7'($urandom);
      len_gpr = REQ_W'($urandom % 100);
      len_cnt = REQ_W'($urandom);
      len_set_mvl = ($urandom % 2) == 0;
      len_mvl_imm = 7'($urandom % 72);
      len_rt_zero = ($urandom % 4) == 0;
      cycle("R2 R5 R11 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule